// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

The block turns a logical address into a real address. The logical address is a segment number plus an offset within that segment. The segment number selects an entry in a small segment table. That entry holds the base index of the segment's page table and the highest legal offset within the segment. The upper bits of the segment offset form a page number. The page number is added to the page-table base to select a page entry. A present page entry supplies a frame number, and the real address is that frame joined with the low offset bits. Presence and modification are tracked only in page entries; segment entries carry no such bits.

Both tables are internal register arrays. Each has its own write port, which is used while the translator is idle. A request is accepted only in the idle state and walks a fixed sequence of states. `ST_IDLE` moves to `ST_SEG` when a request is accepted. `ST_SEG` reads the segment entry, then moves to `ST_DONE` with a range fault if the offset exceeds the limit, and otherwise to `ST_PAGE`. `ST_PAGE` reads the page entry and moves to `ST_DONE` with either a translation or a page fault. `ST_DONE` always returns to `ST_IDLE`.

Top module: `seg_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, fault_page and fault_range are all 0. Every segment entry and every page entry is cleared to zero, so every page reads as not present.
- R2: A request accepted at clock edge A to a present page raises rsp_valid for exactly the cycle after edge A+2. In that cycle rsp_addr = {frame, offset[OFF_W-1:0]}.
- R3: The page entry used is at index (segment base + page number) modulo the page-table depth, where page number = offset[OFF_W+PAGE_W-1:OFF_W]. The index wraps past the last entry back to 0.
- R4: If the offset is greater than the segment's limit, fault_range is raised for the single cycle after edge A+1, and no page entry is read. fault_seg and fault_pnum carry the segment number and the page number.
- R5: If the selected page entry has its present bit at 0, fault_page is raised for the single cycle after edge A+2, with fault_seg and fault_pnum set.
- R6: A successful write request sets the page's modified bit and rsp_modified is 1. A read leaves the bit unchanged, and rsp_modified shows its stored value.
- R7: A segment whose limit is below one page size maps only page 0. Offsets up to the limit translate through the base entry, and any larger offset gives a range fault.
- R8: req_ready is 0 from acceptance until the translator returns to idle. A req_valid asserted while busy is ignored and produces no outcome.
- R9: Each request produces exactly one outcome. At most one of rsp_valid, fault_page and fault_range is 1 in any cycle, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment-table write strobe |
| seg_wr_idx | input | SEG_W | Segment entry to write |
| seg_wr_base | input | PTI_W | Page-table base index for that segment |
| seg_wr_limit | input | SOFF_W | Highest legal offset in that segment |
| pg_we | input | 1 | Page-table write strobe |
| pg_wr_idx | input | PTI_W | Page entry to write |
| pg_wr_frame | input | FRAME_W | Frame number |
| pg_wr_present | input | 1 | Present bit |
| pg_wr_mod | input | 1 | Modified bit |
| req_valid | input | 1 | Translation request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | SOFF_W | Segment offset |
| req_write | input | 1 | Request is a write access |
| req_ready | output | 1 | Translator idle, request accepted this cycle |
| rsp_valid | output | 1 | Translation completed |
| rsp_addr | output | FRAME_W+OFF_W | Real address |
| rsp_modified | output | 1 | Page modified bit after this access |
| fault_page | output | 1 | Page-not-present fault |
| fault_range | output | 1 | Offset-beyond-limit fault |
| fault_seg | output | SEG_W | Segment number of the faulting request |
| fault_pnum | output | PAGE_W | Page number of the faulting request |

## Verification
The assertions check the following on every cycle:
- the three outcome signals never overlap, and none is held for two cycles;
- a completed translation or page fault is preceded by two busy cycles, and a range fault by one;
- a write that completes always reports a set modified bit;
- req_ready, once it falls, stays low for at least the following cycle.

The correctness of the computed address, the wrap of the page index and the short-segment limit need a model of table contents, so only the bench's scenarios show them. The same holds for the modified bit persisting across later requests, and for a request made while busy being dropped.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEG,
        ST_PAGE,
        ST_DONE
    } xl_state_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W  = 2,
    parameter int PTI_W  = 5,
    parameter int SOFF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PTI_W-1:0]  wr_base,
    input  logic [SOFF_W-1:0] wr_limit,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [PTI_W-1:0]  rd_base,
    output logic [SOFF_W-1:0] rd_limit
);
    localparam int NSEG = 1 << SEG_W;

    logic [PTI_W-1:0]  base_r  [NSEG];
    logic [SOFF_W-1:0] limit_r [NSEG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                base_r[i]  <= '0;
                limit_r[i] <= '0;
            end
        end else if (we) begin
            base_r[wr_idx]  <= wr_base;
            limit_r[wr_idx] <= wr_limit;
        end
    end

    assign rd_base  = base_r[rd_idx];
    assign rd_limit = limit_r[rd_idx];
endmodule

// File: rtl/page_table.sv
module page_table #(
    parameter int PTI_W   = 5,
    parameter int FRAME_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PTI_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_present,
    input  logic               wr_mod,
    input  logic               set_mod,
    input  logic [PTI_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_present,
    output logic               rd_mod
);
    localparam int DEPTH = 1 << PTI_W;

    logic [FRAME_W-1:0] frame_r [DEPTH];
    logic [DEPTH-1:0]   pres_r;
    logic [DEPTH-1:0]   mod_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_r <= '0;
            mod_r  <= '0;
            for (int i = 0; i < DEPTH; i++) frame_r[i] <= '0;
        end else begin
            if (set_mod) mod_r[rd_idx] <= 1'b1;
            if (we) begin
                frame_r[wr_idx] <= wr_frame;
                pres_r[wr_idx]  <= wr_present;
                mod_r[wr_idx]   <= wr_mod;
            end
        end
    end

    assign rd_frame   = frame_r[rd_idx];
    assign rd_present = pres_r[rd_idx];
    assign rd_mod     = mod_r[rd_idx];
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W   = 2,
    parameter int PAGE_W  = 3,
    parameter int OFF_W   = 4,
    parameter int PTI_W   = 5,
    parameter int FRAME_W = 6,
    localparam int SOFF_W = PAGE_W + OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [SEG_W-1:0]         req_seg,
    input  logic [SOFF_W-1:0]        req_off,
    input  logic                     req_write,
    output logic                     req_ready,
    output logic [SEG_W-1:0]         seg_idx,
    input  logic [PTI_W-1:0]         seg_base,
    input  logic [SOFF_W-1:0]        seg_limit,
    output logic [PTI_W-1:0]         pt_idx,
    input  logic [FRAME_W-1:0]       pt_frame,
    input  logic                     pt_present,
    input  logic                     pt_mod,
    output logic                     set_mod,
    output logic                     rsp_valid,
    output logic [FRAME_W+OFF_W-1:0] rsp_addr,
    output logic                     rsp_modified,
    output logic                     fault_page,
    output logic                     fault_range,
    output logic [SEG_W-1:0]         fault_seg,
    output logic [PAGE_W-1:0]        fault_pnum
);
    xl_state_e state, state_nx;

    logic [SEG_W-1:0]  seg_q;
    logic [SOFF_W-1:0] off_q;
    logic              wr_q;
    logic [PTI_W-1:0]  base_q;
    logic [PAGE_W-1:0] page_num;
    logic              over_limit;

    assign page_num   = off_q[SOFF_W-1:OFF_W];
    assign over_limit = off_q > seg_limit;
    assign req_ready  = (state == ST_IDLE);
    assign seg_idx    = seg_q;
    assign pt_idx     = base_q + PTI_W'(page_num);
    assign set_mod    = (state == ST_PAGE) && pt_present && wr_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_SEG;
            ST_SEG:  state_nx = over_limit ? ST_DONE : ST_PAGE;
            ST_PAGE: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q        <= '0;
            off_q        <= '0;
            wr_q         <= 1'b0;
            base_q       <= '0;
            rsp_valid    <= 1'b0;
            rsp_addr     <= '0;
            rsp_modified <= 1'b0;
            fault_page   <= 1'b0;
            fault_range  <= 1'b0;
            fault_seg    <= '0;
            fault_pnum   <= '0;
        end else begin
            rsp_valid   <= 1'b0;
            fault_page  <= 1'b0;
            fault_range <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    seg_q <= req_seg;
                    off_q <= req_off;
                    wr_q  <= req_write;
                end
                ST_SEG: begin
                    base_q <= seg_base;
                    if (over_limit) begin
                        fault_range <= 1'b1;
                        fault_seg   <= seg_q;
                        fault_pnum  <= page_num;
                    end
                end
                ST_PAGE: begin
                    if (pt_present) begin
                        rsp_valid    <= 1'b1;
                        rsp_addr     <= {pt_frame, off_q[OFF_W-1:0]};
                        rsp_modified <= pt_mod | wr_q;
                    end else begin
                        fault_page <= 1'b1;
                        fault_seg  <= seg_q;
                        fault_pnum <= page_num;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // R9: one outcome at a time, each a single-cycle pulse
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, fault_page, fault_range}));
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || fault_page || fault_range) |=>
        !(rsp_valid || fault_page || fault_range));
    // R2 / R5: two busy cycles precede a page-level outcome
    p_page_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || fault_page) |-> (!$past(req_ready) && !$past(req_ready, 2)));
    // R4: a range fault follows exactly one busy cycle after idle
    p_range_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_range |-> (!$past(req_ready) && $past(req_ready, 2)));
    // R6: a completed write always reports the page as modified
    p_write_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wr_q) |-> rsp_modified);
    // R8: once busy, the translator stays busy through the next cycle
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |=> !req_ready);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int SEG_W   = 2,
    parameter int PAGE_W  = 3,
    parameter int OFF_W   = 4,
    parameter int PTI_W   = 5,
    parameter int FRAME_W = 6,
    localparam int SOFF_W = PAGE_W + OFF_W,
    localparam int ADDR_W = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_we,
    input  logic [SEG_W-1:0]   seg_wr_idx,
    input  logic [PTI_W-1:0]   seg_wr_base,
    input  logic [SOFF_W-1:0]  seg_wr_limit,
    input  logic               pg_we,
    input  logic [PTI_W-1:0]   pg_wr_idx,
    input  logic [FRAME_W-1:0] pg_wr_frame,
    input  logic               pg_wr_present,
    input  logic               pg_wr_mod,
    input  logic               req_valid,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [SOFF_W-1:0]  req_off,
    input  logic               req_write,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic               rsp_modified,
    output logic               fault_page,
    output logic               fault_range,
    output logic [SEG_W-1:0]   fault_seg,
    output logic [PAGE_W-1:0]  fault_pnum
);
    logic [SEG_W-1:0]   seg_idx;
    logic [PTI_W-1:0]   seg_base;
    logic [SOFF_W-1:0]  seg_limit;
    logic [PTI_W-1:0]   pt_idx;
    logic [FRAME_W-1:0] pt_frame;
    logic               pt_present;
    logic               pt_mod;
    logic               set_mod;

    seg_table #(.SEG_W(SEG_W), .PTI_W(PTI_W), .SOFF_W(SOFF_W)) u_seg (
        .clk(clk), .rst_n(rst_n),
        .we(seg_we), .wr_idx(seg_wr_idx), .wr_base(seg_wr_base), .wr_limit(seg_wr_limit),
        .rd_idx(seg_idx), .rd_base(seg_base), .rd_limit(seg_limit)
    );

    page_table #(.PTI_W(PTI_W), .FRAME_W(FRAME_W)) u_pt (
        .clk(clk), .rst_n(rst_n),
        .we(pg_we), .wr_idx(pg_wr_idx), .wr_frame(pg_wr_frame),
        .wr_present(pg_wr_present), .wr_mod(pg_wr_mod),
        .set_mod(set_mod), .rd_idx(pt_idx),
        .rd_frame(pt_frame), .rd_present(pt_present), .rd_mod(pt_mod)
    );

    xlate_ctrl #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
                 .PTI_W(PTI_W), .FRAME_W(FRAME_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_write(req_write), .req_ready(req_ready),
        .seg_idx(seg_idx), .seg_base(seg_base), .seg_limit(seg_limit),
        .pt_idx(pt_idx), .pt_frame(pt_frame), .pt_present(pt_present),
        .pt_mod(pt_mod), .set_mod(set_mod),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_modified(rsp_modified),
        .fault_page(fault_page), .fault_range(fault_range),
        .fault_seg(fault_seg), .fault_pnum(fault_pnum)
    );
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    localparam int SEG_W = 2, PAGE_W = 3, OFF_W = 4, PTI_W = 5, FRAME_W = 6;
    localparam int SOFF_W = PAGE_W + OFF_W;
    localparam int ADDR_W = FRAME_W + OFF_W;
    localparam int DEPTH = 1 << PTI_W;
    localparam logic [1:0] K_OK = 2'd1, K_PF = 2'd2, K_RF = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic seg_we = 0, pg_we = 0, pg_wr_present = 0, pg_wr_mod = 0;
    logic [SEG_W-1:0] seg_wr_idx = '0;
    logic [PTI_W-1:0] seg_wr_base = '0, pg_wr_idx = '0;
    logic [SOFF_W-1:0] seg_wr_limit = '0, req_off = '0;
    logic [FRAME_W-1:0] pg_wr_frame = '0;
    logic req_valid = 0, req_write = 0;
    logic [SEG_W-1:0] req_seg = '0;
    logic req_ready, rsp_valid, rsp_modified, fault_page, fault_range;
    logic [ADDR_W-1:0] rsp_addr;
    logic [SEG_W-1:0] fault_seg;
    logic [PAGE_W-1:0] fault_pnum;

    seg_xlate uut (.*);

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [SEG_W-1:0]  seg;
        logic [PAGE_W-1:0] pnum;
        logic              md;
        logic [31:0]       at;
    } exp_t;
    exp_t sb[$];

    // bench model of table contents
    logic [PTI_W-1:0]   m_base [1<<SEG_W];
    logic [SOFF_W-1:0]  m_lim  [1<<SEG_W];
    logic [FRAME_W-1:0] m_frm  [DEPTH];
    logic               m_pres [DEPTH];
    logic               m_mod  [DEPTH];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_seg(input int i, input int b, input int l);
        @(negedge clk);
        seg_we = 1; seg_wr_idx = SEG_W'(i); seg_wr_base = PTI_W'(b); seg_wr_limit = SOFF_W'(l);
        m_base[i] = PTI_W'(b); m_lim[i] = SOFF_W'(l);
        @(negedge clk);
        seg_we = 0;
    endtask

    task automatic set_pg(input int i, input int f, input bit p, input bit m);
        @(negedge clk);
        pg_we = 1; pg_wr_idx = PTI_W'(i); pg_wr_frame = FRAME_W'(f);
        pg_wr_present = p; pg_wr_mod = m;
        m_frm[i] = FRAME_W'(f); m_pres[i] = p; m_mod[i] = m;
        @(negedge clk);
        pg_we = 0;
    endtask

    // driver: predicts outcome, pushes it, issues the request
    task automatic issue(input int s, input int off, input bit wr, input bit poke);
        exp_t e;
        int pn, idx;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        pn = off >> OFF_W;
        idx = (m_base[s] + pn) % DEPTH;
        e = '0;
        e.seg = SEG_W'(s); e.pnum = PAGE_W'(pn);
        if (off > m_lim[s]) begin
            e.kind = K_RF; e.at = cyc + 2;
        end else if (!m_pres[idx]) begin
            e.kind = K_PF; e.at = cyc + 3;
        end else begin
            if (wr) m_mod[idx] = 1'b1;
            e.kind = K_OK; e.at = cyc + 3;
            e.addr = {m_frm[idx], OFF_W'(off)};
            e.md = m_mod[idx];
        end
        sb.push_back(e);
        req_valid = 1; req_seg = SEG_W'(s); req_off = SOFF_W'(off); req_write = wr;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            chk(req_ready == 0, "R8 ready low while busy", req_ready, 0);
            req_valid = 1; req_seg = 0; req_off = 0; req_write = 1;
            @(negedge clk);
            req_valid = 0;
        end
        while (!req_ready) @(negedge clk);
    endtask

    // monitor: pops expected items as outcomes appear
    always @(negedge clk) begin
        if (rst_n && (rsp_valid || fault_page || fault_range)) begin
            exp_t e;
            logic [1:0] k;
            k = rsp_valid ? K_OK : (fault_page ? K_PF : K_RF);
            chk($countones({rsp_valid, fault_page, fault_range}) == 1, "R9 single outcome",
                {rsp_valid, fault_page, fault_range}, 0);
            if (sb.size() == 0) begin
                chk(0, "R9/R8 unexpected outcome", k, 0);
            end else begin
                e = sb.pop_front();
                chk(k == e.kind, "R2/R4/R5 outcome kind", k, e.kind);
                chk(cyc == int'(e.at), "R2/R4/R5 latency", cyc, e.at);
                if (e.kind == K_OK) begin
                    chk(rsp_addr == e.addr, "R2/R3 address", rsp_addr, e.addr);
                    chk(rsp_modified == e.md, "R6 modified", rsp_modified, e.md);
                end else begin
                    chk(fault_seg == e.seg, "R4/R5 fault seg", fault_seg, e.seg);
                    chk(fault_pnum == e.pnum, "R4/R5 fault page", fault_pnum, e.pnum);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < (1 << SEG_W); i++) begin m_base[i] = '0; m_lim[i] = '0; end
        for (int i = 0; i < DEPTH; i++) begin m_frm[i] = '0; m_pres[i] = 0; m_mod[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 ready", req_ready, 1);
        chk({rsp_valid, fault_page, fault_range} == 3'b0, "R1 outputs idle",
            {rsp_valid, fault_page, fault_range}, 0);
        // R1: cleared tables give a page fault for offset 0
        issue(0, 0, 0, 0);

        set_seg(0, 0, 127);
        set_seg(1, 8, 9);
        set_seg(2, 30, 63);
        set_seg(3, 16, 47);
        for (int i = 0; i < DEPTH; i++) set_pg(i, (i * 2 + 1) % 64, (i != 5 && i != 17), 0);

        issue(0, 'h23, 0, 0);  // R2 plain read
        issue(0, 'h57, 1, 0);  // R5 absent page, write does not mark
        issue(0, 'h7F, 0, 0);  // R2 last offset in segment
        issue(1, 9, 0, 0);     // R7 short segment at its limit
        issue(1, 10, 0, 0);    // R7/R4 one past limit
        issue(1, 'h10, 0, 0);  // R7 page 1 of a one-page segment
        issue(2, 'h35, 0, 0);  // R3 index wraps 30+3 -> 1
        issue(2, 'h40, 0, 0);  // R4 beyond limit
        issue(3, 'h12, 0, 0);  // R5 absent page index 17
        issue(3, 'h05, 1, 0);  // R6 write marks page 16
        issue(3, 'h0A, 0, 0);  // R6 read sees mark persist
        issue(3, 'h25, 0, 0);  // R6 other page still clean
        issue(0, 'h31, 0, 1);  // R8 request while busy dropped
        set_pg(5, 9, 1, 0);
        issue(0, 'h57, 1, 0);  // R6 write after page made present
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R9 all outcomes seen", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule